// File: doc/BRIEF.md
# PTP Egress Timestamp Inserter

This block sits in a transmit packet stream with a 64-bit data path, start-of-packet and end-of-packet markers and an empty-byte count on the last beat. For each frame it can write the current egress time of day into the frame's timestamp field, using either a 10-byte layout or an 8-byte layout. It can also add the frame's residence time, egress time minus a supplied ingress time, to the frame's 64-bit correction field. The block works on the bytes in flight. It does not locate the fields itself, it does not recompute the frame check sequence, and it does not generate time.

All per-frame controls are sampled on the start-of-packet beat and held for the whole frame: the stamp enable, the layout select, the residence enable, the ingress-form select, both ingress timestamps, and the byte offsets of the timestamp field and the correction field. The time of day is sampled on that same beat. Byte 0 of a frame is bits [63:56] of its first beat. Each beat carries 8 bytes, with the earliest byte in the most significant lane. A field may straddle two beats.

The input valid signal must stay high from start-of-packet through end-of-packet. Both fields must lie inside the frame. If the two fields overlap, the correction field wins on the shared bytes.

Top module: `ptp_tx_stamper`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0.
- R2: A frame with `stamp_en`=0 and `resid_en`=0 on its start-of-packet beat leaves the block byte-for-byte unchanged. Each beat appears on the output two advancing cycles after it was accepted. Frame byte n is lane n mod 8 of beat n div 8, and lane 0 is bits [63:56].
- R3: With `stamp_en`=1 and `stamp_fmt_old`=0, the 10 bytes starting at `ts_off` become {seconds[47:0], nanoseconds[31:0]}, most significant byte first. The 16-bit fractional nanoseconds value is added, unsigned, to the 64-bit big-endian correction field at `cf_off`.
- R4: With `stamp_en`=1 and `stamp_fmt_old`=1, the 8 bytes starting at `ts_off` become {seconds[31:0], nanoseconds[31:0]}, most significant byte first. The correction field is not touched unless `resid_en` is set.
- R5: With `resid_en`=1 and `ing_sel64`=0, the correction field gains the residence time in units of 2^-16 ns. The ingress value is taken from `ing_ts96` = {seconds[47:0], nanoseconds[31:0], fraction[15:0]}. The difference is computed as ((Δsec·10^9 + Δns)·2^16 + Δfrac), so nanoseconds borrow from seconds.
- R6: With `resid_en`=1 and `ing_sel64`=1, the ingress value is `ing_ts64` = {nanoseconds[47:0], fraction[15:0]}. The egress value is formed as {(sec·10^9+ns) mod 2^48, frac}, and the correction field gains the 64-bit difference between the two.
- R7: The controls, offsets, ingress values and time of day are used only as sampled on the start-of-packet beat. Changes on later beats of the frame have no effect.
- R8: A timestamp field or correction field that crosses a beat boundary is patched correctly in both beats.
- R9: `in_ready` equals `out_ready`. While `out_ready` is 0 the whole pipeline holds, and the output beat stays stable.
- R10: `out_sop`, `out_eop` and `out_empty` travel with their data beat.
- R11: When stamping with `stamp_fmt_old`=0 and residence update are both requested, the correction field gains the sum of the fraction and the residence time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_empty | input | 3 | Unused bytes in the last beat |
| in_data | input | 64 | Input beat, earliest byte in [63:56] |
| stamp_en | input | 1 | Write egress time into the timestamp field |
| stamp_fmt_old | input | 1 | 0: 10-byte layout, 1: 8-byte layout |
| resid_en | input | 1 | Add residence time to the correction field |
| ing_sel64 | input | 1 | 0: use the 96-bit ingress form, 1: use the 64-bit form |
| ing_ts96 | input | 96 | Ingress time {sec48, ns32, frac16} |
| ing_ts64 | input | 64 | Ingress time {ns48, frac16} |
| ts_off | input | 8 | Byte offset of the timestamp field |
| cf_off | input | 8 | Byte offset of the correction field |
| tod_sec | input | 48 | Free-running time of day, seconds |
| tod_ns | input | 32 | Free-running time of day, nanoseconds |
| tod_frac | input | 16 | Free-running time of day, 2^-16 ns |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready; low stalls the pipeline |
| out_sop | output | 1 | First beat of a frame |
| out_eop | output | 1 | Last beat of a frame |
| out_empty | output | 3 | Unused bytes in the last beat |
| out_data | output | 64 | Output beat |

## Verification
Two operations can hit the same beat: a straddling correction field and a downstream stall. The correction field's old value is gathered from the beat being patched and the beat behind it. That forces the addition and the stall to meet in the same cycle, so the bench places the field across a beat boundary while it drops `out_ready` at random. Stamping with the 10-byte layout and residence update can also land on the same correction field in the same frame. A behavioural model computes every expected output byte from the sampled controls and compares it on each clock. The model also checks the latency and checks that the output holds during a stall.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;

   localparam logic [63:0] NS_PER_SEC = 64'd1_000_000_000;

   // per-frame state captured on the start-of-packet beat
   typedef struct packed {
      logic        ins;
      logic        fmt_old;
      logic        res;
      logic [47:0] sec;
      logic [31:0] ns;
      logic [15:0] frac;
      logic [63:0] resid;
   } frame_ctx_t;

   // timestamp image, left aligned in 80 bits, MSB first on the wire
   function automatic logic [79:0] ts_image(input logic fmt_old,
                                            input logic [47:0] sec,
                                            input logic [31:0] ns);
      return fmt_old ? {sec[31:0], ns, 16'h0000} : {sec, ns};
   endfunction

endpackage

// File: rtl/ptp_resid_calc.sv
module ptp_resid_calc
   import ptp_stamp_pkg::*;
#(
   parameter bit ING64_EN = 1'b1
) (
   input  logic [47:0] e_sec,
   input  logic [31:0] e_ns,
   input  logic [15:0] e_frac,
   input  logic [95:0] ing96,
   input  logic [63:0] ing64,
   input  logic        sel64,
   output logic [63:0] resid
);

   logic signed [63:0] d_sec;
   logic signed [63:0] d_ns;
   logic signed [63:0] d_frac;
   logic signed [63:0] r96;

   always_comb begin
      d_sec  = $signed({16'd0, e_sec})  - $signed({16'd0, ing96[95:48]});
      d_ns   = $signed({32'd0, e_ns})   - $signed({32'd0, ing96[47:16]});
      d_frac = $signed({48'd0, e_frac}) - $signed({48'd0, ing96[15:0]});
      r96    = ((d_sec * $signed(NS_PER_SEC) + d_ns) <<< 16) + d_frac;
   end

   generate
      if (ING64_EN) begin : g_two_forms
         logic [63:0] eg64;
         always_comb begin
            eg64  = {48'({16'd0, e_sec} * NS_PER_SEC + {32'd0, e_ns}), e_frac};
            resid = sel64 ? (eg64 - ing64) : r96;
         end
      end else begin : g_wide_only
         always_comb resid = r96;
      end
   endgenerate

endmodule

// File: rtl/ptp_frame_ctx.sv
module ptp_frame_ctx
   import ptp_stamp_pkg::*;
#(
   parameter int OFF_W    = 8,
   parameter bit ING64_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             stamp_en,
   input  logic             stamp_fmt_old,
   input  logic             resid_en,
   input  logic             ing_sel64,
   input  logic [95:0]      ing_ts96,
   input  logic [63:0]      ing_ts64,
   input  logic [OFF_W-1:0] ts_off,
   input  logic [OFF_W-1:0] cf_off,
   input  logic [47:0]      tod_sec,
   input  logic [31:0]      tod_ns,
   input  logic [15:0]      tod_frac,
   output frame_ctx_t       ctx,
   output logic [OFF_W-1:0] ts_off_q,
   output logic [OFF_W-1:0] cf_off_q
);

   logic [63:0] resid_now;

   ptp_resid_calc #(.ING64_EN(ING64_EN)) u_resid (
      .e_sec  (tod_sec),
      .e_ns   (tod_ns),
      .e_frac (tod_frac),
      .ing96  (ing_ts96),
      .ing64  (ing_ts64),
      .sel64  (ing_sel64),
      .resid  (resid_now)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ctx      <= '0;
         ts_off_q <= '0;
         cf_off_q <= '0;
      end else if (load) begin
         ctx.ins     <= stamp_en;
         ctx.fmt_old <= stamp_fmt_old;
         ctx.res     <= resid_en;
         ctx.sec     <= tod_sec;
         ctx.ns      <= tod_ns;
         ctx.frac    <= tod_frac;
         ctx.resid   <= resid_now;
         ts_off_q    <= ts_off;
         cf_off_q    <= cf_off;
      end
   end

endmodule

// File: rtl/ptp_lane_patch.sv
module ptp_lane_patch
   import ptp_stamp_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int OFF_W  = 8,
   parameter int POS_W  = 13
) (
   input  logic [DATA_W-1:0] a_data,
   input  logic [DATA_W-1:0] nxt_data,
   input  logic [POS_W-1:0]  a_pos,
   input  frame_ctx_t        ctx,
   input  logic [OFF_W-1:0]  ts_off,
   input  logic [OFF_W-1:0]  cf_off,
   input  logic [63:0]       cf_hold,
   output logic [DATA_W-1:0] patched,
   output logic              cf_here,
   output logic [63:0]       cf_new
);

   localparam int BYTES  = DATA_W / 8;
   localparam int TS_LEN = 10;
   localparam int TS_OLD = 8;
   localparam int CF_LEN = 8;

   logic [POS_W-1:0] ts_base, cf_base, cf_rel, ts_len;
   logic [63:0]      old_cf, cf_add, cf_use;
   logic [79:0]      ts_img;
   logic             cf_act;

   always_comb begin
      ts_base = POS_W'(ts_off);
      cf_base = POS_W'(cf_off);
      cf_rel  = cf_base - a_pos;
      cf_here = (cf_base >= a_pos) && (cf_base < a_pos + POS_W'(BYTES));
      old_cf  = 64'(({a_data, nxt_data} << {cf_rel, 3'b000}) >> (2 * DATA_W - 64));
      cf_add  = ((ctx.ins && !ctx.fmt_old) ? {48'd0, ctx.frac} : 64'd0)
              + (ctx.res ? ctx.resid : 64'd0);
      cf_new  = old_cf + cf_add;
      cf_use  = cf_here ? cf_new : cf_hold;
      cf_act  = ctx.res || (ctx.ins && !ctx.fmt_old);
      ts_img  = ts_image(ctx.fmt_old, ctx.sec, ctx.ns);
      ts_len  = ctx.fmt_old ? POS_W'(TS_OLD) : POS_W'(TS_LEN);
   end

   generate
      for (genvar l = 0; l < BYTES; l++) begin : g_lane
         logic [POS_W-1:0] p, r_ts, r_cf;
         logic             hit_ts, hit_cf;
         logic [7:0]       b_in, b_ts, b_cf;
         always_comb begin
            p      = a_pos + POS_W'(l);
            r_ts   = p - ts_base;
            r_cf   = p - cf_base;
            hit_ts = ctx.ins && (p >= ts_base) && (p < ts_base + ts_len);
            hit_cf = cf_act && (p >= cf_base) && (p < cf_base + POS_W'(CF_LEN));
            b_in   = a_data[DATA_W-1-8*l -: 8];
            b_ts   = 8'((ts_img << {r_ts, 3'b000}) >> 72);
            b_cf   = 8'((cf_use << {r_cf, 3'b000}) >> 56);
            patched[DATA_W-1-8*l -: 8] = hit_cf ? b_cf : (hit_ts ? b_ts : b_in);
         end
      end
   endgenerate

endmodule

// File: rtl/ptp_tx_stamper.sv
module ptp_tx_stamper
   import ptp_stamp_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int OFF_W    = 8,
   parameter bit ING64_EN = 1'b1,
   localparam int BYTES   = DATA_W / 8,
   localparam int EMPTY_W = $clog2(BYTES)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic               in_sop,
   input  logic               in_eop,
   input  logic [EMPTY_W-1:0] in_empty,
   input  logic [DATA_W-1:0]  in_data,
   input  logic               stamp_en,
   input  logic               stamp_fmt_old,
   input  logic               resid_en,
   input  logic               ing_sel64,
   input  logic [95:0]        ing_ts96,
   input  logic [63:0]        ing_ts64,
   input  logic [OFF_W-1:0]   ts_off,
   input  logic [OFF_W-1:0]   cf_off,
   input  logic [47:0]        tod_sec,
   input  logic [31:0]        tod_ns,
   input  logic [15:0]        tod_frac,
   output logic               out_valid,
   input  logic               out_ready,
   output logic               out_sop,
   output logic               out_eop,
   output logic [EMPTY_W-1:0] out_empty,
   output logic [DATA_W-1:0]  out_data
);

   localparam int POS_W = OFF_W + EMPTY_W + 2;

   generate
      if ((DATA_W % 8) != 0 || DATA_W < 64) begin : g_bad_width
         $error("ptp_tx_stamper: DATA_W must be a multiple of 8 and at least 64");
      end
      if (OFF_W < 4) begin : g_bad_off
         $error("ptp_tx_stamper: OFF_W too small for any field position");
      end
   endgenerate

   logic               adv, take;
   logic [POS_W-1:0]   pos_cnt, in_pos;
   logic               a_valid, a_sop, a_eop;
   logic [EMPTY_W-1:0] a_empty;
   logic [DATA_W-1:0]  a_data;
   logic [POS_W-1:0]   a_pos;
   logic               b_valid, b_sop, b_eop;
   logic [EMPTY_W-1:0] b_empty;
   logic [DATA_W-1:0]  b_data;
   logic [63:0]        cf_hold, cf_new;
   logic               cf_here;
   logic [DATA_W-1:0]  patched;
   frame_ctx_t         ctx;
   logic [OFF_W-1:0]   ts_off_q, cf_off_q;

   assign adv      = out_ready;
   assign take     = adv && in_valid;
   assign in_ready = out_ready;
   assign in_pos   = in_sop ? '0 : pos_cnt;

   ptp_frame_ctx #(.OFF_W(OFF_W), .ING64_EN(ING64_EN)) u_ctx (
      .clk           (clk),
      .rst           (rst),
      .load          (take && in_sop),
      .stamp_en      (stamp_en),
      .stamp_fmt_old (stamp_fmt_old),
      .resid_en      (resid_en),
      .ing_sel64     (ing_sel64),
      .ing_ts96      (ing_ts96),
      .ing_ts64      (ing_ts64),
      .ts_off        (ts_off),
      .cf_off        (cf_off),
      .tod_sec       (tod_sec),
      .tod_ns        (tod_ns),
      .tod_frac      (tod_frac),
      .ctx           (ctx),
      .ts_off_q      (ts_off_q),
      .cf_off_q      (cf_off_q)
   );

   ptp_lane_patch #(.DATA_W(DATA_W), .OFF_W(OFF_W), .POS_W(POS_W)) u_patch (
      .a_data   (a_data),
      .nxt_data (in_data),
      .a_pos    (a_pos),
      .ctx      (ctx),
      .ts_off   (ts_off_q),
      .cf_off   (cf_off_q),
      .cf_hold  (cf_hold),
      .patched  (patched),
      .cf_here  (cf_here),
      .cf_new   (cf_new)
   );

   // beat position counter; stops once past every reachable field
   always_ff @(posedge clk) begin
      if (rst) begin
         pos_cnt <= '0;
      end else if (take) begin
         if (!in_pos[POS_W-1]) pos_cnt <= in_pos + POS_W'(BYTES);
         else                  pos_cnt <= in_pos;
      end
   end

   // stage A: raw beat; stage B: patched beat driving the outputs
   always_ff @(posedge clk) begin
      if (rst) begin
         a_valid <= 1'b0;
         a_sop   <= 1'b0;
         a_eop   <= 1'b0;
         a_empty <= '0;
         a_data  <= '0;
         a_pos   <= '0;
         b_valid <= 1'b0;
         b_sop   <= 1'b0;
         b_eop   <= 1'b0;
         b_empty <= '0;
         b_data  <= '0;
         cf_hold <= '0;
      end else if (adv) begin
         a_valid <= in_valid;
         a_sop   <= in_sop;
         a_eop   <= in_eop;
         a_empty <= in_empty;
         a_data  <= in_data;
         a_pos   <= in_pos;
         b_valid <= a_valid;
         b_sop   <= a_sop;
         b_eop   <= a_eop;
         b_empty <= a_empty;
         b_data  <= patched;
         if (a_valid && cf_here) cf_hold <= cf_new;
      end
   end

   assign out_valid = b_valid;
   assign out_sop   = b_sop;
   assign out_eop   = b_eop;
   assign out_empty = b_empty;
   assign out_data  = b_data;

endmodule

// File: rtl/ptp_tx_stamper_chk.sv
module ptp_tx_stamper_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_ready,
   input logic              in_sop,
   input logic [DATA_W-1:0] in_data,
   input logic              stamp_en,
   input logic              resid_en,
   input logic              out_valid,
   input logic              out_ready,
   input logic              out_sop,
   input logic              out_eop,
   input logic [DATA_W-1:0] out_data
);

   AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_valid); // R1

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)); // R9

   AST_SOP_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && in_sop) ##1 out_ready |=> out_valid && out_sop); // R10

   AST_PASS_FIRST_BEAT: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && in_sop && !stamp_en && !resid_en) ##1 out_ready
      |=> out_data == $past(in_data, 2)); // R2

endmodule

bind ptp_tx_stamper ptp_tx_stamper_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_sop    (in_sop),
   .in_data   (in_data),
   .stamp_en  (stamp_en),
   .resid_en  (resid_en),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_sop   (out_sop),
   .out_eop   (out_eop),
   .out_data  (out_data)
);

// File: tb/ptp_tx_stamper_test.sv
`timescale 1ns/1ps
module ptp_tx_stamper_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
   logic [2:0]  in_empty = '0;
   logic [63:0] in_data = '0;
   logic        in_ready;
   logic        stamp_en = 1'b0, stamp_fmt_old = 1'b0, resid_en = 1'b0, ing_sel64 = 1'b0;
   logic [95:0] ing_ts96 = '0;
   logic [63:0] ing_ts64 = '0;
   logic [7:0]  ts_off = '0, cf_off = '0;
   logic [47:0] tod_sec = '0;
   logic [31:0] tod_ns = '0;
   logic [15:0] tod_frac = '0;
   logic        out_valid, out_sop, out_eop;
   logic        out_ready = 1'b1;
   logic [2:0]  out_empty;
   logic [63:0] out_data;

   typedef struct {
      logic [63:0] data;
      logic        sop;
      logic        eop;
      logic [2:0]  empty;
      string       tag;
   } beat_t;

   beat_t exp_q[$];
   int    due_q[$];
   int    adv = 0;
   int    checks = 0;
   int    errors = 0;
   bit    stall_mode = 1'b0;
   bit    done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   ptp_tx_stamper uut (.*);

   // acceptance bookkeeping: a beat taken at an advancing edge shows two advancing edges later
   always @(posedge clk) begin
      if (!rst && out_ready) begin
         if (in_valid) due_q.push_back(adv + 2);
         adv++;
      end
   end

   // per-clock comparison against the reference model, then next ready value
   always @(negedge clk) begin
      bit nr;
      nr = stall_mode ? ($urandom_range(0, 3) != 0) : 1'b1;
      if (!rst && !done) begin
         checks++;
         if (in_ready !== out_ready) begin
            errors++;
            $display("FAIL R9: in_ready=%b expected %b", in_ready, out_ready);
         end
         if (due_q.size() > 0 && due_q[0] == adv) begin
            beat_t e;
            e = exp_q[0];
            checks++;
            if (out_valid !== 1'b1 || out_data !== e.data || out_sop !== e.sop ||
                out_eop !== e.eop || out_empty !== e.empty) begin
               errors++;
               $display("FAIL %s: valid=%b data=%h sop=%b eop=%b empty=%0d expected valid=1 data=%h sop=%b eop=%b empty=%0d",
                        e.tag, out_valid, out_data, out_sop, out_eop, out_empty,
                        e.data, e.sop, e.eop, e.empty);
            end
            if (nr) begin
               void'(exp_q.pop_front());
               void'(due_q.pop_front());
            end
         end else begin
            checks++;
            if (out_valid !== 1'b0) begin
               errors++;
               $display("FAIL R2 R10: out_valid=%b expected 0 (no beat due)", out_valid);
            end
         end
      end
      out_ready = rst ? 1'b1 : nr;
   end

   function automatic logic [63:0] ref_resid(bit s64, logic [47:0] es, logic [31:0] en,
                                             logic [15:0] ef, logic [95:0] i96, logic [63:0] i64);
      longint d;
      if (!s64) begin
         d = (longint'(es) - longint'(i96[95:48])) * 1000000000
           + (longint'(en) - longint'(i96[47:16]));
         d = d * 65536 + (longint'(ef) - longint'(i96[15:0]));
         return d;
      end else begin
         longint      t;
         logic [63:0] e64;
         t   = longint'(es) * 1000000000 + longint'(en);
         e64 = {t[47:0], ef};
         return e64 - i64;
      end
   endfunction

   task automatic run_frame(int len, bit ins, bit fo, bit res, bit s64, int tso, int cfo,
                            logic [95:0] i96, logic [63:0] i64,
                            logic [47:0] es, logic [31:0] en, logic [15:0] ef, string tag);
      logic [7:0] fr[256];
      logic [7:0] ex[256];
      int nb;
      nb = (len + 7) / 8;
      for (int i = 0; i < nb * 8; i++) begin
         fr[i] = (i < len) ? 8'($urandom) : 8'h00;
         ex[i] = fr[i];
      end
      if (ins) begin
         logic [79:0] img;
         img = fo ? {es[31:0], en, 16'h0} : {es, en};
         for (int k = 0; k < (fo ? 8 : 10); k++) ex[tso + k] = img[79 - 8*k -: 8];
      end
      if (res || (ins && !fo)) begin
         logic [63:0] oc;
         oc = '0;
         for (int k = 0; k < 8; k++) oc = {oc[55:0], fr[cfo + k]};
         if (ins && !fo) oc = oc + {48'd0, ef};
         if (res) oc = oc + ref_resid(s64, es, en, ef, i96, i64);
         for (int k = 0; k < 8; k++) ex[cfo + k] = oc[63 - 8*k -: 8];
      end
      for (int b = 0; b < nb; b++) begin
         beat_t e;
         for (int l = 0; l < 8; l++) e.data[63 - 8*l -: 8] = ex[b*8 + l];
         e.sop   = (b == 0);
         e.eop   = (b == nb - 1);
         e.empty = (b == nb - 1) ? 3'(nb * 8 - len) : 3'd0;
         e.tag   = tag;
         exp_q.push_back(e);
      end
      for (int b = 0; b < nb; b++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sop   = (b == 0);
         in_eop   = (b == nb - 1);
         in_empty = (b == nb - 1) ? 3'(nb * 8 - len) : 3'd0;
         for (int l = 0; l < 8; l++) in_data[63 - 8*l -: 8] = fr[b*8 + l];
         if (b == 0) begin
            stamp_en = ins; stamp_fmt_old = fo; resid_en = res; ing_sel64 = s64;
            ing_ts96 = i96; ing_ts64 = i64; ts_off = 8'(tso); cf_off = 8'(cfo);
            tod_sec = es; tod_ns = en; tod_frac = ef;
         end else begin
            // R7: scramble every sideband input and the time after the first beat
            stamp_en = ~ins; stamp_fmt_old = ~fo; resid_en = ~res; ing_sel64 = ~s64;
            ing_ts96 = {$urandom, $urandom, $urandom}; ing_ts64 = {$urandom, $urandom};
            ts_off = 8'($urandom); cf_off = 8'($urandom);
            tod_sec = tod_sec + 48'd3; tod_ns = tod_ns + 32'd777; tod_frac = tod_frac + 16'd5;
         end
         do @(posedge clk); while (!out_ready);
      end
   endtask

   task automatic go_idle(int n);
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: out_valid=%b expected 0 during reset", out_valid);
      end
      rst = 1'b0;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: out_valid=%b expected 0 after reset", out_valid);
      end

      run_frame(30, 0, 0, 0, 0, 0, 0, '0, '0, 48'd9, 32'd9, 16'd9, "R2 R10 pass");
      go_idle(2);
      run_frame(64, 1, 0, 0, 0, 34, 8, '0, '0, 48'h12_3456_789A, 32'd305419896, 16'hBEEF,
                "R3 R8 new layout");
      run_frame(60, 1, 1, 0, 0, 16, 0, '0, '0, 48'hAA_BBCC_DDEE, 32'd123456789, 16'h1234,
                "R4 old layout");
      go_idle(1);
      run_frame(48, 0, 0, 1, 0, 0, 20, {48'd98, 32'd999_999_990, 16'h0020}, '0,
                48'd100, 32'd5, 16'h0010, "R5 R8 resid wide borrow");
      run_frame(40, 0, 0, 1, 1, 0, 8, '0, {48'(64'd3_000_000_100), 16'h8000},
                48'd3, 32'd500, 16'h0000, "R6 resid narrow");
      run_frame(72, 1, 0, 1, 0, 40, 24, {48'd7, 32'd999_000_000, 16'hFFFF}, '0,
                48'd8, 32'd1000, 16'h0001, "R11 stamp plus resid");
      run_frame(5, 0, 0, 0, 0, 0, 0, '0, '0, 48'd1, 32'd1, 16'd1, "R2 R10 short");
      go_idle(3);

      stall_mode = 1'b1;
      for (int i = 0; i < 8; i++) begin
         run_frame(40 + 8*i + (i % 3), (i % 2) == 0, (i % 4) == 2, i > 2, (i % 3) == 1,
                   3*i, 28 + i,
                   {48'(50 + i), 32'(999_999_000 + i), 16'(i)},
                   {48'(64'd49_999_999_000 + i), 16'h0100},
                   48'(51 + i), 32'(250 + 9*i), 16'(300 + i), "R9 R7 R8 stalled");
         if (i == 3) go_idle(2);
      end
      go_idle(1);
      stall_mode = 1'b0;

      while (exp_q.size() > 0) @(negedge clk);
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, %0d beats still expected, expected 0", exp_q.size());
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule